// File: doc/BRIEF.md
# Split Base-and-Bound Address Translator

This block relocates and limit-checks addresses for a simple in-order core that keeps instruction fetches and data accesses in separate segments. It holds four 32-bit registers: a relocation base and a limit for the fetch side, and another base and limit for the load/store side. Each side adds its own base to the incoming logical address and compares the logical address against its own limit. The adder and comparator work in parallel. The result is registered, so the physical address, the pass strobe and the fault flag appear one cycle after the request.

A request whose logical address is equal to or greater than the side's limit is a fault. A faulting access produces no pass strobe, and its physical address output is forced to zero. The two sides share nothing but the clock, so each can return a result in the same cycle.

Software programs the four registers through a single write port. The port takes effect only while the core is in supervisor mode. A write attempted in user mode changes nothing and raises a one-cycle privilege-error pulse.

Top module: `bbx_translator`

## Requirements
- R1: After synchronous reset all four registers are zero and every output is low, so any request made straight after reset faults (a limit of zero admits no address).
- R2: A fetch request with logical address A returns, on the clock after it is presented, if_vld=1 and if_paddr = fetch base + A.
- R3: The load/store side uses only the data base and data limit, and a change to the fetch pair does not alter its result (and the reverse).
- R4: A side faults when its logical address is greater than or equal to its limit: A = limit faults, A = limit-1 passes.
- R5: A faulting access gives fault=1, vld=0 and a physical address output of zero; vld and fault are never both high.
- R6: A write with cfg_we=1 and sup_mode=0 leaves every register unchanged and raises priv_err for exactly the one cycle after the write.
- R7: A write with cfg_we=1 and sup_mode=1 loads cfg_wdata into the register chosen by cfg_sel (0 fetch base, 1 fetch limit, 2 data base, 3 data limit) at that clock edge. It raises no priv_err, and requests in later cycles use the new value.
- R8: Fetch and load/store requests presented in the same cycle both produce their own correct results in the same later cycle.
- R9: In a cycle after no request on a side, that side's vld and fault are low and its physical address output is zero.
- R10: The base addition wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_mode | input | 1 | 1 when the core runs in supervisor mode |
| cfg_we | input | 1 | Register write request |
| cfg_sel | input | 2 | Register select: 0 fetch base, 1 fetch limit, 2 data base, 3 data limit |
| cfg_wdata | input | 32 | Register write data |
| if_req | input | 1 | Fetch translation request |
| if_laddr | input | 32 | Fetch logical address (program counter) |
| if_vld | output | 1 | Fetch result valid, memory strobe passed |
| if_fault | output | 1 | Fetch bounds violation |
| if_paddr | output | 32 | Fetch physical address |
| ls_req | input | 1 | Load/store translation request |
| ls_laddr | input | 32 | Load/store logical address |
| ls_vld | output | 1 | Load/store result valid, memory strobe passed |
| ls_fault | output | 1 | Load/store bounds violation |
| ls_paddr | output | 32 | Load/store physical address |
| priv_err | output | 1 | One-cycle pulse after a user-mode register write |

## Verification
The bench tests the limit at its edge: one address exactly equal to the limit and one just below it. An off-by-one comparator would pass the first or fault the second. User-mode writes are followed by translations on both sides, which shows any register the write wrongly changed through a shifted physical address or a changed fault. Crossed register selects are caught by programming different values into the fetch pair and the data pair and then translating on both sides in the same cycle. A base near the top of the address space tests the wrapping addition, and idle cycles show whether a design leaves stale addresses or strobes on its outputs.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
    localparam int ADDR_W = 32;
    localparam int NREG   = 4;
    localparam int SEL_W  = $clog2(NREG);
    localparam int NSIDE  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_IF_BASE  = 2'd0,
        SEL_IF_LIMIT = 2'd1,
        SEL_LS_BASE  = 2'd2,
        SEL_LS_LIMIT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              vld;
        logic              fault;
        logic [ADDR_W-1:0] paddr;
    } xl_res_t;

    function automatic logic outside_limit(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] lim);
        return a >= lim;
    endfunction
endpackage

// File: rtl/bbx_regfile.sv
module bbx_regfile
    import bbx_pkg::*;
#(
    parameter int W = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sup_mode,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [W-1:0]     cfg_wdata,
    output logic [W-1:0]     base_o  [NSIDE],
    output logic [W-1:0]     limit_o [NSIDE],
    output logic             priv_err
);
    logic [W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
            priv_err <= 1'b0;
        end else begin
            if (cfg_we && sup_mode) regs_q[cfg_sel] <= cfg_wdata;
            priv_err <= cfg_we && !sup_mode;
        end
    end

    always_comb begin
        base_o[0]  = regs_q[SEL_IF_BASE];
        limit_o[0] = regs_q[SEL_IF_LIMIT];
        base_o[1]  = regs_q[SEL_LS_BASE];
        limit_o[1] = regs_q[SEL_LS_LIMIT];
    end
endmodule

// File: rtl/bbx_side.sv
module bbx_side
    import bbx_pkg::*;
#(
    parameter int W = ADDR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] laddr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] limit,
    output logic         vld,
    output logic         fault,
    output logic [W-1:0] paddr
);
    logic [W-1:0] sum;
    logic         over;

    always_comb begin
        sum  = base + laddr;
        over = (laddr >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= 1'b0;
            fault <= 1'b0;
            paddr <= '0;
        end else begin
            vld   <= req && !over;
            fault <= req && over;
            paddr <= (req && !over) ? sum : '0;
        end
    end
endmodule

// File: rtl/bbx_translator.sv
module bbx_translator
    import bbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sup_mode,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              if_req,
    input  logic [ADDR_W-1:0] if_laddr,
    output logic              if_vld,
    output logic              if_fault,
    output logic [ADDR_W-1:0] if_paddr,
    input  logic              ls_req,
    input  logic [ADDR_W-1:0] ls_laddr,
    output logic              ls_vld,
    output logic              ls_fault,
    output logic [ADDR_W-1:0] ls_paddr,
    output logic              priv_err
);
    logic [ADDR_W-1:0] base_w  [NSIDE];
    logic [ADDR_W-1:0] limit_w [NSIDE];
    logic              req_w   [NSIDE];
    logic [ADDR_W-1:0] la_w    [NSIDE];
    logic              vld_w   [NSIDE];
    logic              flt_w   [NSIDE];
    logic [ADDR_W-1:0] pa_w    [NSIDE];

    bbx_regfile #(.W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .sup_mode(sup_mode),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .base_o(base_w), .limit_o(limit_w), .priv_err(priv_err)
    );

    always_comb begin
        req_w[0] = if_req;  la_w[0] = if_laddr;
        req_w[1] = ls_req;  la_w[1] = ls_laddr;
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        bbx_side #(.W(ADDR_W)) u_side (
            .clk(clk), .rst(rst), .req(req_w[g]), .laddr(la_w[g]),
            .base(base_w[g]), .limit(limit_w[g]),
            .vld(vld_w[g]), .fault(flt_w[g]), .paddr(pa_w[g])
        );
    end

    always_comb begin
        if_vld = vld_w[0];  if_fault = flt_w[0];  if_paddr = pa_w[0];
        ls_vld = vld_w[1];  ls_fault = flt_w[1];  ls_paddr = pa_w[1];
    end
endmodule

// File: rtl/bbx_translator_chk.sv
module bbx_translator_chk
    import bbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sup_mode,
    input logic              cfg_we,
    input logic              if_req,
    input logic              if_vld,
    input logic              if_fault,
    input logic [ADDR_W-1:0] if_paddr,
    input logic              ls_req,
    input logic              ls_vld,
    input logic              ls_fault,
    input logic [ADDR_W-1:0] ls_paddr,
    input logic              priv_err
);
    assert_user_write_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !sup_mode) |=> priv_err);
    assert_no_spurious_err_R7: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && !sup_mode) |=> !priv_err);
    assert_if_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(if_vld && if_fault));
    assert_ls_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(ls_vld && ls_fault));
    assert_if_fault_addr_R5: assert property (@(posedge clk) disable iff (rst)
        if_fault |-> (if_paddr == '0));
    assert_ls_fault_addr_R5: assert property (@(posedge clk) disable iff (rst)
        ls_fault |-> (ls_paddr == '0));
    assert_if_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !if_req |=> (!if_vld && !if_fault && if_paddr == '0));
    assert_ls_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !ls_req |=> (!ls_vld && !ls_fault && ls_paddr == '0));
    assert_if_answers_R2: assert property (@(posedge clk) disable iff (rst)
        if_req |=> (if_vld || if_fault));
    assert_ls_answers_R3: assert property (@(posedge clk) disable iff (rst)
        ls_req |=> (ls_vld || ls_fault));
endmodule

bind bbx_translator bbx_translator_chk u_chk (
    .clk(clk), .rst(rst), .sup_mode(sup_mode), .cfg_we(cfg_we),
    .if_req(if_req), .if_vld(if_vld), .if_fault(if_fault), .if_paddr(if_paddr),
    .ls_req(ls_req), .ls_vld(ls_vld), .ls_fault(ls_fault), .ls_paddr(ls_paddr),
    .priv_err(priv_err)
);

// File: tb/tb_bbx_translator.sv
module tb_bbx_translator;
    logic        clk = 1'b0;
    logic        rst;
    logic        sup_mode, cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        if_req, ls_req;
    logic [31:0] if_laddr, ls_laddr;
    logic        if_vld, if_fault, ls_vld, ls_fault, priv_err;
    logic [31:0] if_paddr, ls_paddr;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_reg [4];

    always #2 clk = ~clk;

    bbx_translator dut (
        .clk(clk), .rst(rst), .sup_mode(sup_mode), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .if_req(if_req), .if_laddr(if_laddr), .if_vld(if_vld),
        .if_fault(if_fault), .if_paddr(if_paddr),
        .ls_req(ls_req), .ls_laddr(ls_laddr), .ls_vld(ls_vld),
        .ls_fault(ls_fault), .ls_paddr(ls_paddr), .priv_err(priv_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model-based check of one side's result
    task automatic check_side(string req, int side, logic r, logic [31:0] a,
                              logic v, logic f, logic [31:0] p);
        logic [31:0] b, l;
        logic        o;
        b = m_reg[side*2];
        l = m_reg[side*2+1];
        o = r && (a >= l);
        check({req, " vld"},   {31'd0, v}, {31'd0, r && !o});
        check({req, " fault"}, {31'd0, f}, {31'd0, o});
        check({req, " paddr"}, p, (r && !o) ? b + a : 32'd0);
    endtask

    task automatic write_reg(logic [1:0] sel, logic [31:0] d, logic sup, string req);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; sup_mode = sup;
        @(negedge clk);
        cfg_we = 1'b0; sup_mode = 1'b1;
        if (sup) m_reg[sel] = d;
        check({req, " priv_err pulse"}, {31'd0, priv_err}, {31'd0, !sup});
        @(negedge clk);
        check({req, " priv_err one cycle"}, {31'd0, priv_err}, 32'd0);
    endtask

    task automatic xlate(logic ir, logic [31:0] ia, logic lr, logic [31:0] la, string req);
        @(negedge clk);
        if_req = ir; if_laddr = ia; ls_req = lr; ls_laddr = la;
        @(negedge clk);
        if_req = 1'b0; ls_req = 1'b0;
        check_side({req, " fetch"}, 0, ir, ia, if_vld, if_fault, if_paddr);
        check_side({req, " data"},  1, lr, la, ls_vld, ls_fault, ls_paddr);
    endtask

    task automatic t_reset;
        check("R1 reset if_vld", {31'd0, if_vld}, 32'd0);
        check("R1 reset priv_err", {31'd0, priv_err}, 32'd0);
        xlate(1'b1, 32'h0, 1'b1, 32'h0, "R1 zero limit");
    endtask

    task automatic t_program;
        write_reg(2'd0, 32'h0001_0000, 1'b1, "R7 fetch base");
        write_reg(2'd1, 32'h0000_1000, 1'b1, "R7 fetch limit");
        write_reg(2'd2, 32'h0800_0000, 1'b1, "R7 data base");
        write_reg(2'd3, 32'h0000_0400, 1'b1, "R7 data limit");
        xlate(1'b1, 32'h0000_0123, 1'b0, 32'h0, "R2 fetch");
        xlate(1'b0, 32'h0, 1'b1, 32'h0000_0044, "R3 data");
        xlate(1'b1, 32'h0000_0800, 1'b1, 32'h0000_0800, "R8 both sides");
    endtask

    task automatic t_limit_edge;
        xlate(1'b1, 32'h0000_0FFF, 1'b1, 32'h0000_03FF, "R4 limit-1 pass");
        xlate(1'b1, 32'h0000_1000, 1'b1, 32'h0000_0400, "R4 at limit R5");
        xlate(1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, "R4 top R5");
    endtask

    task automatic t_user_write;
        write_reg(2'd0, 32'hDEAD_0000, 1'b0, "R6 user base");
        write_reg(2'd3, 32'hFFFF_FFFF, 1'b0, "R6 user limit");
        xlate(1'b1, 32'h0000_0010, 1'b1, 32'h0000_0500, "R6 regs unchanged");
    endtask

    task automatic t_independent;
        write_reg(2'd0, 32'h0002_0000, 1'b1, "R3 new fetch base");
        xlate(1'b1, 32'h0000_0020, 1'b1, 32'h0000_0020, "R3 data unaffected");
    endtask

    task automatic t_wrap_idle;
        write_reg(2'd2, 32'hFFFF_FF00, 1'b1, "R10 high base");
        xlate(1'b0, 32'h0, 1'b1, 32'h0000_0180, "R10 wrap");
        xlate(1'b0, 32'h0000_0001, 1'b0, 32'h0000_0001, "R9 idle");
    endtask

    initial begin
        rst = 1'b1; sup_mode = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
        if_req = 1'b0; ls_req = 1'b0; if_laddr = '0; ls_laddr = '0;
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_limit_edge();
        t_user_write();
        t_independent();
        t_wrap_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule